// File: doc/BRIEF.md
# Scan-Accessed Trace Buffer Register Port

This block gives a debug host access to the registers of an on-chip trace capture buffer through a boundary-scan data register. The TAP controller in front of it is reduced to single-cycle strobes for capture, shift and update, plus the serial TDI input and TDO output. Each scan moves a 40-bit frame through the block. The frame holds a 32-bit data word, a 7-bit register address and a direction flag.

A write frame commits its data word into the addressed register at the update strobe. A read frame latches the addressed register's value at the update strobe. The host receives that value in the data field of the next scan, so one read costs two scans. Reading the trace-RAM data address returns the word at the RAM read pointer and then moves the pointer forward. This lets back-to-back read scans drain the buffer.

The block connects to the capture core as follows:
- It drives the RAM read address.
- It takes in the RAM word, the status word and the core's write pointer.
- It holds the control and trigger-count registers.
- It hands a host-written write-pointer value to the core with a one-cycle load strobe.

Top module: `trace_reg_port`

## Requirements
- R1: A frame is 40 bits, shifted in on TDI and out on TDO least significant bit first. Bits 31:0 are data, bits 38:32 are the register address, and bit 39 is the direction flag (1 = write, 0 = read). The shift register advances one bit per clock while shiftDr is high. TDO shows the current bit 0.
- R2: At updateDr with flag 1, the data field is written into the addressed register. Address 7 is the trigger count (trigCount) and address 8 is control (ctrlOut). Both take effect in the cycle after the update strobe and read back unchanged.
- R3: At updateDr with flag 0, the addressed value is latched. At the next captureDr, the data field of the outgoing frame is loaded with the latch and the address and flag fields are loaded with zero. The latch changes only on read frames.
- R4: Address 0 reads the ID_CODE parameter, address 1 reads the RAM depth (DEPTH) and address 2 reads the RAM word width (RAM_WIDTH).
- R5: A read of address 4 latches ramRdData at the current read pointer (ramRdAddr) and then increments the pointer by one. The pointer wraps from DEPTH-1 to 0.
- R6: A read of any address other than 4 leaves the read pointer unchanged.
- R7: Writes to addresses 0, 1 and 2 are ignored. These addresses keep returning their constants, and no other register or output changes.
- R8: A read of an address above 8 returns zero. A write to an address above 8 changes no register or output.
- R9: Address 3 reads statusIn and address 6 reads wrPtrIn. A write to address 6 places the data word on wrPtrLoadVal and pulses wrPtrLoadStb high for exactly one cycle, in the cycle after the update strobe.
- R10: Address 5 reads the read pointer zero-extended to 32 bits. A write to address 5 loads the pointer from the low data bits.
- R11: After reset, the read latch, read pointer, control, trigger count and load strobe are all zero. The first scan therefore shifts out an all-zero frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| captureDr | input | 1 | Capture strobe: loads read latch into the shift frame |
| shiftDr | input | 1 | Shift strobe: one bit per clock |
| updateDr | input | 1 | Update strobe: executes the frame's request |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (frame bit 0) |
| statusIn | input | 32 | Capture core status word |
| wrPtrIn | input | PTR_W | Capture core write pointer |
| ramRdData | input | 32 | Trace RAM word at ramRdAddr |
| ramRdAddr | output | PTR_W | Trace RAM read pointer |
| ctrlOut | output | 32 | Control register |
| trigCount | output | 32 | Trigger count register |
| wrPtrLoadVal | output | PTR_W | Write pointer value to load into the core |
| wrPtrLoadStb | output | 1 | One-cycle load strobe for wrPtrLoadVal |

## Verification
The bench checks the one-scan lag of read data:
- A design that returned data in the same scan would show the wrong word on every vector.
- A design whose latch is disturbed by write frames would corrupt the answer of a read followed by a write.

Repeated RAM-data reads are run across the end of the buffer. A pointer that failed to advance, advanced on other reads, or failed to wrap would return repeated or wrong RAM words.

Writes to the constant addresses and to addresses above 8 are followed by reads of every writable register. Any address decode that aliases on fewer bits would then show a changed value.

// File: rtl/trace_reg_pkg.sv
package trace_reg_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 7;
  localparam int FRAME_W = DATA_W + ADDR_W + 1;

  localparam logic [ADDR_W-1:0] A_IDENT  = 7'd0;
  localparam logic [ADDR_W-1:0] A_DEPTH  = 7'd1;
  localparam logic [ADDR_W-1:0] A_WIDTH  = 7'd2;
  localparam logic [ADDR_W-1:0] A_STATUS = 7'd3;
  localparam logic [ADDR_W-1:0] A_RAMDAT = 7'd4;
  localparam logic [ADDR_W-1:0] A_RDPTR  = 7'd5;
  localparam logic [ADDR_W-1:0] A_WRPTR  = 7'd6;
  localparam logic [ADDR_W-1:0] A_TRIG   = 7'd7;
  localparam logic [ADDR_W-1:0] A_CTRL   = 7'd8;

  // strobes from the scan control to the register datapath
  typedef struct packed {
    logic              rdEn;
    logic              wrEn;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } regCmd_t;
endpackage

// File: rtl/trace_scan_ctl.sv
module trace_scan_ctl
  import trace_reg_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                captureDr,
  input  logic                shiftDr,
  input  logic                updateDr,
  input  logic                tdi,
  input  logic [DATA_W-1:0]   readLatch,
  output logic                tdo,
  output regCmd_t             cmd
);
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frame <= '0;
    end else if (captureDr) begin
      frame <= {{(FRAME_W-DATA_W){1'b0}}, readLatch};
    end else if (shiftDr) begin
      frame <= {tdi, frame[FRAME_W-1:1]};
    end
  end

  assign tdo = frame[0];

  always_comb begin
    cmd.wrEn = updateDr &  frame[FRAME_W-1];
    cmd.rdEn = updateDr & ~frame[FRAME_W-1];
    cmd.addr = frame[FRAME_W-2:DATA_W];
    cmd.data = frame[DATA_W-1:0];
  end
endmodule

// File: rtl/trace_reg_dp.sv
module trace_reg_dp
  import trace_reg_pkg::*;
#(
  parameter logic [31:0] ID_CODE   = 32'h4B1D_0A21,
  parameter int          DEPTH     = 16,
  parameter int          RAM_WIDTH = 32,
  localparam int         PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regCmd_t           cmd,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [PTR_W-1:0]  wrPtrIn,
  input  logic [DATA_W-1:0] ramRdData,
  output logic [DATA_W-1:0] readLatch,
  output logic [PTR_W-1:0]  ramRdAddr,
  output logic [DATA_W-1:0] ctrlOut,
  output logic [DATA_W-1:0] trigCount,
  output logic [PTR_W-1:0]  wrPtrLoadVal,
  output logic              wrPtrLoadStb
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0]  readPtr;
  logic [DATA_W-1:0] readMux;
  logic [PTR_W-1:0]  ptrNext;

  always_comb begin
    case (cmd.addr)
      A_IDENT:  readMux = ID_CODE;
      A_DEPTH:  readMux = DATA_W'(DEPTH);
      A_WIDTH:  readMux = DATA_W'(RAM_WIDTH);
      A_STATUS: readMux = statusIn;
      A_RAMDAT: readMux = ramRdData;
      A_RDPTR:  readMux = DATA_W'(readPtr);
      A_WRPTR:  readMux = DATA_W'(wrPtrIn);
      A_TRIG:   readMux = trigCount;
      A_CTRL:   readMux = ctrlOut;
      default:  readMux = '0;
    endcase
  end

  assign ptrNext = (readPtr == LAST_PTR) ? '0 : readPtr + 1'b1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readLatch    <= '0;
      readPtr      <= '0;
      ctrlOut      <= '0;
      trigCount    <= '0;
      wrPtrLoadVal <= '0;
      wrPtrLoadStb <= 1'b0;
    end else begin
      wrPtrLoadStb <= 1'b0;
      if (cmd.rdEn) begin
        readLatch <= readMux;
        if (cmd.addr == A_RAMDAT) readPtr <= ptrNext;
      end
      if (cmd.wrEn) begin
        case (cmd.addr)
          A_RDPTR: readPtr   <= cmd.data[PTR_W-1:0];
          A_TRIG:  trigCount <= cmd.data;
          A_CTRL:  ctrlOut   <= cmd.data;
          A_WRPTR: begin
            wrPtrLoadVal <= cmd.data[PTR_W-1:0];
            wrPtrLoadStb <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assign ramRdAddr = readPtr;
endmodule

// File: rtl/trace_reg_port.sv
module trace_reg_port
  import trace_reg_pkg::*;
#(
  parameter logic [31:0] ID_CODE   = 32'h4B1D_0A21,
  parameter int          DEPTH     = 16,
  parameter int          RAM_WIDTH = 32,
  localparam int         PTR_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             captureDr,
  input  logic             shiftDr,
  input  logic             updateDr,
  input  logic             tdi,
  output logic             tdo,
  input  logic [31:0]      statusIn,
  input  logic [PTR_W-1:0] wrPtrIn,
  input  logic [31:0]      ramRdData,
  output logic [PTR_W-1:0] ramRdAddr,
  output logic [31:0]      ctrlOut,
  output logic [31:0]      trigCount,
  output logic [PTR_W-1:0] wrPtrLoadVal,
  output logic             wrPtrLoadStb
);
  regCmd_t           cmd;
  logic [DATA_W-1:0] readLatch;

  trace_scan_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .captureDr (captureDr),
    .shiftDr   (shiftDr),
    .updateDr  (updateDr),
    .tdi       (tdi),
    .readLatch (readLatch),
    .tdo       (tdo),
    .cmd       (cmd)
  );

  trace_reg_dp #(
    .ID_CODE   (ID_CODE),
    .DEPTH     (DEPTH),
    .RAM_WIDTH (RAM_WIDTH)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .statusIn     (statusIn),
    .wrPtrIn      (wrPtrIn),
    .ramRdData    (ramRdData),
    .readLatch    (readLatch),
    .ramRdAddr    (ramRdAddr),
    .ctrlOut      (ctrlOut),
    .trigCount    (trigCount),
    .wrPtrLoadVal (wrPtrLoadVal),
    .wrPtrLoadStb (wrPtrLoadStb)
  );
endmodule

// File: rtl/trace_reg_port_chk.sv
module trace_reg_port_chk
  import trace_reg_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic             clk,
  input logic             rstN,
  input regCmd_t          cmd,
  input logic [PTR_W-1:0] ramRdAddr,
  input logic [31:0]      ctrlOut,
  input logic [31:0]      trigCount,
  input logic             wrPtrLoadStb
);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  // R5: a RAM-data read moves the pointer on by one, wrapping at the end
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdEn && cmd.addr == A_RAMDAT) |=>
      ramRdAddr == (($past(ramRdAddr) == LAST_PTR) ? '0 : $past(ramRdAddr) + 1'b1));

  // R6: other reads leave the pointer alone
  a_r6_ptr_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.rdEn && cmd.addr != A_RAMDAT) |=> $stable(ramRdAddr));

  // R7: writes to the constant addresses disturb nothing
  a_r7_const_wr_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrEn && cmd.addr <= A_WIDTH) |=>
      ($stable(ctrlOut) && $stable(trigCount) && $stable(ramRdAddr) && !wrPtrLoadStb));

  // R8: writes above the map disturb nothing
  a_r8_high_wr_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cmd.wrEn && cmd.addr > A_CTRL) |=>
      ($stable(ctrlOut) && $stable(trigCount) && $stable(ramRdAddr) && !wrPtrLoadStb));

  // R9: the load strobe only follows a write to the write-pointer address
  a_r9_load_strobe: assert property (@(posedge clk) disable iff (!rstN)
    wrPtrLoadStb |-> $past(cmd.wrEn && cmd.addr == A_WRPTR));
endmodule

bind trace_reg_port trace_reg_port_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cmd          (cmd),
  .ramRdAddr    (ramRdAddr),
  .ctrlOut      (ctrlOut),
  .trigCount    (trigCount),
  .wrPtrLoadStb (wrPtrLoadStb)
);

// File: tb/trace_reg_port_tb.sv
`timescale 1ns/1ps
module trace_reg_port_tb;
  localparam logic [31:0] ID   = 32'h4B1D_0A21;
  localparam int          DEP  = 16;
  localparam int          RW   = 32;
  localparam int          PW   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic captureDr = 0, shiftDr = 0, updateDr = 0, tdi = 0;
  logic tdo;
  logic [31:0] statusIn = 32'h0000_000B;
  logic [PW-1:0] wrPtrIn = 4'd9;
  logic [31:0] ramRdData;
  logic [PW-1:0] ramRdAddr, wrPtrLoadVal;
  logic [31:0] ctrlOut, trigCount;
  logic wrPtrLoadStb;

  always #4 clk = ~clk;

  function automatic logic [31:0] ramWord(input logic [PW-1:0] a);
    return {8'hA5, 4'h0, a, 16'hC0DE ^ {12'h0, a}};
  endfunction
  assign ramRdData = ramWord(ramRdAddr);

  trace_reg_port #(.ID_CODE(ID), .DEPTH(DEP), .RAM_WIDTH(RW)) u_dut (
    .clk(clk), .rstN(rstN), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .tdi(tdi), .tdo(tdo), .statusIn(statusIn),
    .wrPtrIn(wrPtrIn), .ramRdData(ramRdData), .ramRdAddr(ramRdAddr),
    .ctrlOut(ctrlOut), .trigCount(trigCount), .wrPtrLoadVal(wrPtrLoadVal),
    .wrPtrLoadStb(wrPtrLoadStb));

  int nChecks = 0, nFails = 0;
  logic [39:0] expQ[$];
  logic [39:0] obsQ[$];
  string tagQ[$];

  // model state
  logic [31:0] mLatch = '0, mCtrl = '0, mTrig = '0;
  logic [PW-1:0] mPtr = '0;

  task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] modelRead(input logic [6:0] a);
    case (a)
      7'd0: return ID;
      7'd1: return DEP;
      7'd2: return RW;
      7'd3: return statusIn;
      7'd4: return ramWord(mPtr);
      7'd5: return {28'h0, mPtr};
      7'd6: return {28'h0, wrPtrIn};
      7'd7: return mTrig;
      7'd8: return mCtrl;
      default: return 32'h0;
    endcase
  endfunction

  // driver: one full scan, pushes expected outgoing frame, updates model
  task automatic scan(input string tag, input bit wr, input logic [6:0] a, input logic [31:0] d);
    logic [39:0] f, got;
    f = {wr, a, d};
    expQ.push_back({8'h00, mLatch});
    tagQ.push_back(tag);
    @(negedge clk) captureDr = 1;
    @(negedge clk) captureDr = 0; shiftDr = 1;
    for (int i = 0; i < 40; i++) begin
      tdi = f[i];
      got[i] = tdo;
      @(negedge clk);
    end
    shiftDr = 0; updateDr = 1;
    @(negedge clk) updateDr = 0;
    obsQ.push_back(got);
    if (wr) begin
      case (a)
        7'd5: mPtr = d[PW-1:0];
        7'd7: mTrig = d;
        7'd8: mCtrl = d;
        default: ;
      endcase
    end else begin
      mLatch = modelRead(a);
      if (a == 7'd4) mPtr = mPtr + 1'b1;
    end
  endtask

  // monitor: compares shifted-out frames against the expected ones
  initial begin
    forever begin
      wait (obsQ.size() > 0);
      begin
        logic [39:0] o, e;
        string t;
        o = obsQ.pop_front(); e = expQ.pop_front(); t = tagQ.pop_front();
        check(t, o, e);
      end
    end
  end

  task automatic outs(input string tag);
    check({tag, " ctrl"}, {8'h0, ctrlOut}, {8'h0, mCtrl});
    check({tag, " trig"}, {8'h0, trigCount}, {8'h0, mTrig});
    check({tag, " ptr"}, {36'h0, ramRdAddr}, {36'h0, mPtr});
  endtask

  bit finished = 0;
  initial begin
    #(8 * 150000);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R11 reset state
    outs("R11 reset");
    check("R11 strobe", {39'h0, wrPtrLoadStb}, 40'h0);
    scan("R11 first frame zero / R4 id req", 0, 7'd0, 32'hFFFF_FFFF);
    scan("R4 id returned / R1 frame", 0, 7'd1, 32'h0);
    scan("R4 depth", 0, 7'd2, 32'h0);
    scan("R4 width", 0, 7'd3, 32'h0);
    scan("R9 status", 0, 7'd6, 32'h0);
    scan("R9 wrptr read", 1, 7'd7, 32'hDEAD_BEEF);
    // R3: latch kept through a write scan
    scan("R3 latch after write", 1, 7'd8, 32'h1234_5678);
    outs("R2 write");
    scan("R3 latch held", 0, 7'd7, 32'h0);
    scan("R2 trig readback", 0, 7'd8, 32'h0);
    // R9 write pointer load strobe
    scan("R2 ctrl readback", 1, 7'd6, 32'h0000_0005);
    check("R9 stb high", {39'h0, wrPtrLoadStb}, 40'h1);
    check("R9 load val", {36'h0, wrPtrLoadVal}, 40'h5);
    @(negedge clk);
    check("R9 stb one cycle", {39'h0, wrPtrLoadStb}, 40'h0);
    // R10 read pointer write / read
    scan("R10 pre", 1, 7'd5, 32'hFFFF_FFFD);
    outs("R10 ptr set");
    scan("R10 ptr read req", 0, 7'd5, 32'h0);
    // R5 RAM drain across the wrap
    for (int k = 0; k < 5; k++) scan("R5 ram read", 0, 7'd4, 32'h0);
    outs("R5 wrap");
    // R6 id read has no side effect
    scan("R5 last ram word", 0, 7'd0, 32'h0);
    outs("R6 no advance");
    scan("R6 id", 0, 7'd3, 32'h0);
    outs("R6 status read no advance");
    // R7 writes to constants ignored
    scan("R7 pre", 1, 7'd0, 32'h0BAD_0BAD);
    scan("R7 w1", 1, 7'd1, 32'h0BAD_0BAD);
    scan("R7 w2", 1, 7'd2, 32'h0BAD_0BAD);
    check("R7 no stb", {39'h0, wrPtrLoadStb}, 40'h0);
    outs("R7 state");
    scan("R7 r0", 0, 7'd0, 32'h0);
    scan("R7 id kept", 0, 7'd1, 32'h0);
    scan("R7 depth kept", 0, 7'd2, 32'h0);
    // R8 high addresses
    scan("R7 width kept", 1, 7'd9, 32'h5555_AAAA);
    check("R8 no stb", {39'h0, wrPtrLoadStb}, 40'h0);
    scan("R8 w", 1, 7'd72, 32'h5555_AAAA);
    outs("R8 state");
    scan("R8 pre", 0, 7'd8, 32'h0);
    scan("R8 ctrl kept", 0, 7'd9, 32'h0);
    scan("R8 addr9 zero", 0, 7'd127, 32'h0);
    scan("R8 addr127 zero", 0, 7'd7, 32'h0);
    scan("R8 trig kept", 0, 7'd0, 32'h0);
    wait (obsQ.size() == 0);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule